// File: doc/BRIEF.md
# Sign-Magnitude Fixed-Point Adder

This block adds two fixed-point numbers held in sign-magnitude form and returns their sum in the same form. It has no clock. A word is N bits wide. The most significant bit is the sign (1 means negative). Below it sit N-Q-1 integer bits, and the lowest Q bits hold the fraction. The two operands and the result all share this layout. The formats are set by the parameters `N` and `Q`.

The sign is kept apart from the magnitude, so a plain binary add cannot be used. The block first decides which operand has the larger magnitude. When the signs agree it adds the two magnitudes. When they differ it subtracts the smaller magnitude from the larger. It then chooses the sign of the result.

To subtract, the user inverts the sign bit of the second operand before it reaches the block. No overflow is reported. A magnitude sum that does not fit in N-1 bits silently loses its carry.

Top module: `fxsm_adder`

## Requirements
- R1: Bit N-1 of every word is the sign (1 = negative), and bits N-2..0 are an unsigned magnitude in units of 2^-Q. For example, with N=16 and Q=8, 0x0180 is +1.5 and 0x8040 is -0.25.
- R2: When both operand signs are equal and the result magnitude is non-zero, the result magnitude is the sum of the operand magnitudes and the result sign is the shared sign.
- R3: When the operand signs differ, the result magnitude is the larger magnitude minus the smaller, and the result sign is the sign of the operand with the larger magnitude.
- R4: Operands of equal magnitude and opposite sign give the result 0 with the sign bit clear.
- R5: A result with zero magnitude always carries a clear sign bit. This holds also for inputs that are negative zero (0x8000 when N=16).
- R6: When like-signed magnitudes sum to 2^(N-1) or more, the result magnitude is the sum modulo 2^(N-1), and no other output indicates it.
- R7: Setting the sign bit of `b` to the opposite value and adding yields a - b, under the same wrap rule as R6.
- R8: The block is combinational: `c` follows `a` and `b` within the same clock cycle that they change, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, sign-magnitude fixed point |
| b | input | N | Second operand, sign-magnitude fixed point |
| c | output | N | Sum, same format as the operands |

## Verification
Three situations are hard to reach with random operands.

- **Exact cancellation:** two operands of opposite sign and the same magnitude are needed to test the forced positive zero. Random draws with a 15-bit magnitude almost never produce this.
- **Negative-zero inputs:** these must be built on purpose.
- **Wrap on like-signed sums:** this needs both magnitudes in the upper part of the range.

The bench therefore derives operands from one another. It negates a random operand against itself, and it sends negative zero on one or both inputs. It also draws magnitude pairs that it biases above half of full scale. Each case is compared against an integer model that converts both words to signed values, adds them, and re-encodes the result.

// File: rtl/fxsm_pkg.sv
package fxsm_pkg;
   typedef enum logic {
      MAG_ADD = 1'b0,
      MAG_SUB = 1'b1
   } mag_op_e;
endpackage

// File: rtl/fxsm_mag_order.sv
module fxsm_mag_order #(
   parameter int W = 15
) (
   input  logic [W-1:0] x_mag,
   input  logic [W-1:0] y_mag,
   output logic         y_wins,
   output logic [W-1:0] big_mag,
   output logic [W-1:0] small_mag
);
   always_comb begin
      y_wins    = (y_mag > x_mag);
      big_mag   = y_wins ? y_mag : x_mag;
      small_mag = y_wins ? x_mag : y_mag;
   end

   always_comb begin
      p_order_r3: assert (big_mag >= small_mag)
         else $error("p_order_r3: larger magnitude below smaller");
   end
endmodule

// File: rtl/fxsm_mag_arith.sv
module fxsm_mag_arith
   import fxsm_pkg::*;
#(
   parameter int W = 15
) (
   input  mag_op_e      op,
   input  logic [W-1:0] big_mag,
   input  logic [W-1:0] small_mag,
   output logic [W-1:0] res_mag
);
   // The carry out of the top magnitude bit is dropped on purpose (R6).
   always_comb begin
      if (op == MAG_SUB) res_mag = big_mag - small_mag;
      else               res_mag = big_mag + small_mag;
   end

   always_comb begin
      if (op == MAG_SUB)
         p_sub_bound_r3: assert (res_mag <= big_mag)
            else $error("p_sub_bound_r3: difference exceeds minuend");
   end
endmodule

// File: rtl/fxsm_sign_pick.sv
module fxsm_sign_pick (
   input  logic sign_x,
   input  logic sign_y,
   input  logic y_wins,
   input  logic mag_zero,
   output logic sign_out
);
   always_comb begin
      if (mag_zero)              sign_out = 1'b0;
      else if (sign_x == sign_y) sign_out = sign_x;
      else                       sign_out = y_wins ? sign_y : sign_x;
   end
endmodule

// File: rtl/fxsm_adder.sv
module fxsm_adder
   import fxsm_pkg::*;
#(
   parameter int N = 16,
   parameter int Q = 8
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [N-1:0] c
);
   localparam int MAG_W = N - 1;
   localparam int INT_W = N - Q - 1;

   generate
      if (N < 2) begin : g_bad_width
         $error("fxsm_adder: N must be at least 2");
      end
      if (Q < 0 || INT_W < 0) begin : g_bad_frac
         $error("fxsm_adder: Q must lie in 0..N-1");
      end
   endgenerate

   logic             sa, sb, y_wins, res_sign, mag_zero;
   logic [MAG_W-1:0] ma, mb, big_mag, small_mag, res_mag;
   mag_op_e          op;

   assign sa = a[N-1];
   assign sb = b[N-1];
   assign ma = a[MAG_W-1:0];
   assign mb = b[MAG_W-1:0];
   assign op = (sa == sb) ? MAG_ADD : MAG_SUB;

   fxsm_mag_order #(.W(MAG_W)) u_order (
      .x_mag(ma), .y_mag(mb), .y_wins(y_wins),
      .big_mag(big_mag), .small_mag(small_mag)
   );

   fxsm_mag_arith #(.W(MAG_W)) u_arith (
      .op(op), .big_mag(big_mag), .small_mag(small_mag), .res_mag(res_mag)
   );

   assign mag_zero = (res_mag == '0);

   fxsm_sign_pick u_sign (
      .sign_x(sa), .sign_y(sb), .y_wins(y_wins),
      .mag_zero(mag_zero), .sign_out(res_sign)
   );

   assign c = {res_sign, res_mag};

   always_comb begin
      if (c[MAG_W-1:0] == '0)
         p_zero_pos_r5: assert (!c[N-1])
            else $error("p_zero_pos_r5: negative zero on c");
      if (sa == sb && c[MAG_W-1:0] != '0)
         p_same_sign_r2: assert (c[N-1] == sa)
            else $error("p_same_sign_r2: sign differs from shared sign");
      if (sa == sb && c[MAG_W-1:0] < ma)
         p_wrap_both_r6: assert (c[MAG_W-1:0] < mb)
            else $error("p_wrap_both_r6: partial wrap");
      if (sa != sb && ma == mb)
         p_cancel_r4: assert (c == '0)
            else $error("p_cancel_r4: cancellation not +0");
      if (sa != sb && ma > mb)
         p_bigger_a_r3: assert (c[N-1] == sa)
            else $error("p_bigger_a_r3: sign not from a");
   end
endmodule

// File: tb/fxsm_adder_test.sv
module fxsm_adder_test;
   localparam int N = 16;
   localparam int Q = 8;
   localparam longint MOD = longint'(1) << (N - 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0] a = '0, b = '0;
   logic [N-1:0] c;
   int total = 0, bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fxsm_adder #(.N(N), .Q(Q)) uut (.a(a), .b(b), .c(c));

   function automatic longint to_int(input logic [N-1:0] w);
      longint m = longint'(w[N-2:0]);
      return w[N-1] ? -m : m;
   endfunction

   function automatic logic [N-1:0] model(input logic [N-1:0] x, input logic [N-1:0] y);
      longint s = to_int(x) + to_int(y);
      longint m = (s < 0 ? -s : s) % MOD;
      logic [N-1:0] r;
      r = N'(m);
      r[N-1] = (s < 0) && (m != 0);
      return r;
   endfunction

   task automatic check(input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
      logic [N-1:0] exp;
      @(posedge clk);
      a <= x;
      b <= y;
      @(negedge clk);
      exp = model(x, y);
      total++;
      if (c !== exp) begin
         bad++;
         $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, x, y, c, exp);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      total++;
      if (c !== '0) begin
         bad++;
         $display("FAIL reset actual=%h expected=0000", c);
      end
      check(16'h0180, 16'h0040, "R1 1.5+0.25");
      check(16'h0180, 16'h8040, "R1 1.5-0.25");
      check(16'h8100, 16'h8080, "R2 neg+neg");
      check(16'h0123, 16'h0456, "R2 pos+pos");
      check(16'h0100, 16'h8300, "R3 b larger neg");
      check(16'h8300, 16'h0100, "R3 a larger neg");
      check(16'h0050, 16'h8020, "R3 a larger pos");
      check(16'h0777, 16'h8777, "R4 cancel");
      check(16'h8777, 16'h0777, "R4 cancel rev");
      check(16'h8000, 16'h8000, "R5 negzero both");
      check(16'h8000, 16'h0000, "R5 negzero mix");
      check(16'h8000, 16'h8005, "R5 negzero plus neg");
      check(16'h7FFF, 16'h0001, "R6 wrap to zero");
      check(16'hFFFF, 16'hC000, "R6 wrap neg");
      check(16'h6000, 16'h3000, "R6 wrap pos");
      check(16'h0300, 16'h0100 ^ 16'h8000, "R7 3-1");
      check(16'h0100, 16'h0300 ^ 16'h8000, "R7 1-3");
      check(16'h8200, 16'h8200 ^ 16'h8000, "R7 -2-(-2)");
      for (int i = 0; i < 400; i++) begin
         logic [N-1:0] x, y;
         x = N'($urandom);
         y = N'($urandom);
         case (i % 4)
            0: check(x, y, "R8 random");
            1: check(x, x ^ {1'b1, {(N-1){1'b0}}}, "R4 random cancel");
            2: check(x | 16'h4000, (y | 16'h4000) & 16'h7FFF | (x & 16'h8000), "R6 random high");
            default: check(x, y ^ {1'b1, {(N-1){1'b0}}}, "R7 random sub");
         endcase
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule